// File: doc/BRIEF.md
# Address Tenure Bus Master

This block runs the address phase of a split-transaction processor bus, where the address phase and the data phase are arbitrated on their own. A client hands it one transfer at a time through a ready/valid handshake: a 32-bit address and a 5-bit transfer-type code. The block raises a bus request and waits for a qualified grant. It then owns the address bus and drives the start strobe, the busy signal, the address and the transfer type until the target acknowledges the address. One cycle after that acknowledge it lets go of the bus.

On the receive side the block watches the start-strobe input for transfers begun by other masters. Each foreign strobe leaves a one-cycle snoop-valid pulse, together with the address and type that were on the bus. Tri-state pins are modelled as value and output-enable pairs. The block does not handle data-bus arbitration, the data phase or snoop responses. It only asks for the data bus when the transfer type needs a data phase.

Top module: `addr_tenure_master`

## Requirements
- R1: After a synchronous reset, `bus_req`, `start_out`, `busy_out`, `dbus_req`, `snoop_valid` and every output enable are 0, and `req_ready` is 1.
- R2: A request is taken only when `req_valid` and `req_ready` are both high at a clock edge. From the next cycle `bus_req` is 1 and `req_ready` is 0.
- R3: A grant is qualified when `grant_in` is 1, `busy_in` is 0 and `bus_req` is 1. A grant seen while `busy_in` is 1 is ignored: no strobe follows. `bus_req` is 0 from the cycle after the qualified grant.
- R4: `start_out` and `start_oe` are 1 in the cycle after a qualified grant. `start_out` stays 1 for exactly that one cycle. That cycle is also the first cycle of `busy_out`=1.
- R5: `addr_out` and `ttype_out` are valid, with `addr_oe`=1, from the strobe cycle on. They stay constant through the whole tenure.
- R6: When bit 1 of the transfer type is 1 (burst), `addr_out` has its low 3 bits cleared, so it is aligned to 8 bytes. Otherwise the address is passed through unchanged.
- R7: After `aack_in` is sampled high during the tenure (the strobe cycle included), the next cycle has `start_oe`=0, `addr_oe`=0 and `busy_out`=0, with `busy_oe` still 1. One cycle later `busy_oe`=0 and `req_ready`=1.
- R8: When bit 3 of the transfer type is 0 (data phase needed), `dbus_req` is a one-cycle pulse that coincides with `start_out`. When bit 3 is 1 it stays 0.
- R9: When `start_in` is 1 at an edge outside the block's own strobe and tenure cycles, `snoop_valid` is 1 for the next cycle. `snoop_addr` and `snoop_ttype` then hold the `addr_in` and `ttype_in` values sampled at that edge. The block's own strobe seen on `start_in` gives no snoop pulse.
- R10: `req_valid` during a tenure has no effect. The address stays the same, and no new bus request follows the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client offers a transfer |
| req_ready | output | 1 | Block can take a transfer |
| req_addr | input | 32 | Transfer address |
| req_ttype | input | 5 | Transfer-type code |
| bus_req | output | 1 | Address-bus request to the arbiter |
| grant_in | input | 1 | Address-bus grant |
| busy_in | input | 1 | Address bus busy as seen on the bus |
| busy_out | output | 1 | Busy value driven by the block |
| busy_oe | output | 1 | Busy output enable |
| start_in | input | 1 | Start strobe seen on the bus |
| start_out | output | 1 | Start strobe driven by the block |
| start_oe | output | 1 | Start strobe output enable |
| addr_in | input | 32 | Address seen on the bus |
| addr_out | output | 32 | Address driven by the block |
| addr_oe | output | 1 | Address and type output enable |
| ttype_in | input | 5 | Transfer type seen on the bus |
| ttype_out | output | 5 | Transfer type driven by the block |
| aack_in | input | 1 | Address acknowledge from the target |
| dbus_req | output | 1 | Data-bus request pulse |
| snoop_valid | output | 1 | Foreign transfer captured |
| snoop_addr | output | 32 | Captured foreign address |
| snoop_ttype | output | 5 | Captured foreign transfer type |

## Verification
The assertions check the local timing rules on every cycle:
- the one-cycle strobe and its coincidence with the start of busy;
- the drop of the bus request;
- the stable address during the tenure and the alignment of burst addresses;
- the release pattern after acknowledge;
- the data-bus pulse staying inside the strobe cycle;
- the silence of the snoop path during the block's own tenure.

Only the bench scenarios can show the values themselves. These include which address and type reach the bus for each type code, and that grants arriving while the bus is busy delay the strobe. They also include what the snoop registers capture, and that requests offered mid-tenure leave no trace.

// File: rtl/atm_pkg.sv
package atm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_START,
    ST_TENURE,
    ST_REL
  } atm_state_e;

  localparam int TT_BURST_BIT  = 1;
  localparam int TT_NODATA_BIT = 3;
  localparam int ALIGN_BITS    = 3;
endpackage

// File: rtl/atm_req_capture.sv
module atm_req_capture #(
  parameter int ADDR_W = 32,
  parameter int TT_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TT_W-1:0]   ttype,
  output logic [ADDR_W-1:0] addr_q,
  output logic [TT_W-1:0]   ttype_q,
  output logic              need_data_q
);
  import atm_pkg::*;

  localparam int AB = ALIGN_BITS;

  logic [ADDR_W-1:0] addr_eff;

  always_comb begin
    if (ttype[TT_BURST_BIT]) addr_eff = {addr[ADDR_W-1:AB], {AB{1'b0}}};
    else                     addr_eff = addr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q      <= '0;
      ttype_q     <= '0;
      need_data_q <= 1'b0;
    end else if (load) begin
      addr_q      <= addr_eff;
      ttype_q     <= ttype;
      need_data_q <= ~ttype[TT_NODATA_BIT];
    end
  end
endmodule

// File: rtl/atm_tenure_fsm.sv
module atm_tenure_fsm (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic grant_in,
  input  logic busy_in,
  input  logic aack_in,
  input  logic need_data,
  output logic req_ready,
  output logic load,
  output logic bus_req,
  output logic start_out,
  output logic start_oe,
  output logic busy_out,
  output logic busy_oe,
  output logic drive_oe,
  output logic dbus_req,
  output logic own_tenure
);
  import atm_pkg::*;

  atm_state_e state;

  assign req_ready  = (state == ST_IDLE);
  assign load       = req_valid && req_ready;
  assign own_tenure = (state == ST_START) || (state == ST_TENURE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bus_req   <= 1'b0;
      start_out <= 1'b0;
      start_oe  <= 1'b0;
      busy_out  <= 1'b0;
      busy_oe   <= 1'b0;
      drive_oe  <= 1'b0;
      dbus_req  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            state   <= ST_REQ;
            bus_req <= 1'b1;
          end
        end
        ST_REQ: begin
          if (grant_in && !busy_in && bus_req) begin
            state     <= ST_START;
            bus_req   <= 1'b0;
            start_out <= 1'b1;
            start_oe  <= 1'b1;
            busy_out  <= 1'b1;
            busy_oe   <= 1'b1;
            drive_oe  <= 1'b1;
            dbus_req  <= need_data;
          end
        end
        ST_START, ST_TENURE: begin
          start_out <= 1'b0;
          dbus_req  <= 1'b0;
          if (aack_in) begin
            state    <= ST_REL;
            start_oe <= 1'b0;
            drive_oe <= 1'b0;
            busy_out <= 1'b0;
          end else begin
            state <= ST_TENURE;
          end
        end
        ST_REL: begin
          busy_oe <= 1'b0;
          state   <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: strobe lasts one cycle
  p_start_single_r4: assert property (@(posedge clk) disable iff (rst)
    start_out |=> !start_out);
  // R4: strobe opens the busy window
  p_start_opens_busy_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(start_out) |-> $rose(busy_out) && start_oe);
  // R3: request gone once the strobe is out
  p_req_dropped_r3: assert property (@(posedge clk) disable iff (rst)
    start_out |-> !bus_req);
  // R3: no strobe follows a grant while busy
  p_no_grant_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (bus_req && busy_in) |=> !start_out);
  // R7: release pattern after acknowledge
  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (start_oe && aack_in) |=> (!start_oe && !drive_oe && !busy_out && busy_oe));
  // R8: data request only with the strobe
  p_dbus_with_start_r8: assert property (@(posedge clk) disable iff (rst)
    dbus_req |-> start_out);
endmodule

// File: rtl/atm_snoop_cap.sv
module atm_snoop_cap #(
  parameter int ADDR_W = 32,
  parameter int TT_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_in,
  input  logic              own_tenure,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [TT_W-1:0]   ttype_in,
  output logic              snoop_valid,
  output logic [ADDR_W-1:0] snoop_addr,
  output logic [TT_W-1:0]   snoop_ttype
);
  logic foreign;

  assign foreign = start_in && !own_tenure;

  always_ff @(posedge clk) begin
    if (rst) begin
      snoop_valid <= 1'b0;
      snoop_addr  <= '0;
      snoop_ttype <= '0;
    end else begin
      snoop_valid <= foreign;
      if (foreign) begin
        snoop_addr  <= addr_in;
        snoop_ttype <= ttype_in;
      end
    end
  end

  // R9: own strobe never reported
  p_self_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (start_in && own_tenure) |=> !snoop_valid);
endmodule

// File: rtl/addr_tenure_master.sv
module addr_tenure_master #(
  parameter int ADDR_W = 32,
  parameter int TT_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TT_W-1:0]   req_ttype,
  output logic              bus_req,
  input  logic              grant_in,
  input  logic              busy_in,
  output logic              busy_out,
  output logic              busy_oe,
  input  logic              start_in,
  output logic              start_out,
  output logic              start_oe,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_oe,
  input  logic [TT_W-1:0]   ttype_in,
  output logic [TT_W-1:0]   ttype_out,
  input  logic              aack_in,
  output logic              dbus_req,
  output logic              snoop_valid,
  output logic [ADDR_W-1:0] snoop_addr,
  output logic [TT_W-1:0]   snoop_ttype
);
  import atm_pkg::*;

  logic load;
  logic need_data;
  logic own_tenure;

  atm_req_capture #(.ADDR_W(ADDR_W), .TT_W(TT_W)) u_cap (
    .clk(clk), .rst(rst), .load(load), .addr(req_addr), .ttype(req_ttype),
    .addr_q(addr_out), .ttype_q(ttype_out), .need_data_q(need_data)
  );

  atm_tenure_fsm u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .grant_in(grant_in),
    .busy_in(busy_in), .aack_in(aack_in), .need_data(need_data),
    .req_ready(req_ready), .load(load), .bus_req(bus_req),
    .start_out(start_out), .start_oe(start_oe), .busy_out(busy_out),
    .busy_oe(busy_oe), .drive_oe(addr_oe), .dbus_req(dbus_req),
    .own_tenure(own_tenure)
  );

  atm_snoop_cap #(.ADDR_W(ADDR_W), .TT_W(TT_W)) u_snoop (
    .clk(clk), .rst(rst), .start_in(start_in), .own_tenure(own_tenure),
    .addr_in(addr_in), .ttype_in(ttype_in), .snoop_valid(snoop_valid),
    .snoop_addr(snoop_addr), .snoop_ttype(snoop_ttype)
  );

  // R5: address and type held through the tenure
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (addr_oe && $past(addr_oe)) |-> ($stable(addr_out) && $stable(ttype_out)));
  // R6: burst addresses are double-word aligned on the bus
  p_burst_align_r6: assert property (@(posedge clk) disable iff (rst)
    (addr_oe && ttype_out[TT_BURST_BIT]) |-> (addr_out[ALIGN_BITS-1:0] == '0));
endmodule

// File: tb/tb_addr_tenure_master.sv
module tb_addr_tenure_master;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_addr = '0;
  logic [4:0] req_ttype = '0;
  logic bus_req, grant_in = 1'b0, busy_in = 1'b0;
  logic busy_out, busy_oe, start_in = 1'b0, start_out, start_oe;
  logic [31:0] addr_in = '0, addr_out;
  logic addr_oe;
  logic [4:0] ttype_in = '0, ttype_out;
  logic aack_in = 1'b0, dbus_req, snoop_valid;
  logic [31:0] snoop_addr;
  logic [4:0] snoop_ttype;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  addr_tenure_master dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_ttype(req_ttype), .bus_req(bus_req),
    .grant_in(grant_in), .busy_in(busy_in), .busy_out(busy_out),
    .busy_oe(busy_oe), .start_in(start_in), .start_out(start_out),
    .start_oe(start_oe), .addr_in(addr_in), .addr_out(addr_out),
    .addr_oe(addr_oe), .ttype_in(ttype_in), .ttype_out(ttype_out),
    .aack_in(aack_in), .dbus_req(dbus_req), .snoop_valid(snoop_valid),
    .snoop_addr(snoop_addr), .snoop_ttype(snoop_ttype)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic tenure(input logic [31:0] a, input logic [4:0] tt,
                        input int blk, input int ackd);
    logic [31:0] exp_a;
    logic exp_d;
    exp_a = tt[1] ? {a[31:3], 3'b000} : a;
    exp_d = ~tt[3];
    @(negedge clk);
    check("R2 ready before", {63'd0, req_ready}, 64'd1);
    req_valid = 1'b1; req_addr = a; req_ttype = tt;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 bus_req", {63'd0, bus_req}, 64'd1);
    check("R2 ready low", {63'd0, req_ready}, 64'd0);
    for (int i = 0; i < blk; i++) begin
      grant_in = 1'b1; busy_in = 1'b1;
      @(negedge clk);
      check("R3 busy grant ignored", {62'd0, start_out, bus_req}, 64'd1);
    end
    grant_in = 1'b1; busy_in = 1'b0;
    @(negedge clk);
    grant_in = 1'b0;
    check("R4 strobe", {59'd0, start_out, start_oe, busy_out, busy_oe, addr_oe}, 64'h1f);
    check("R3 req dropped", {63'd0, bus_req}, 64'd0);
    check("R5 addr R6 align", {32'd0, addr_out}, {32'd0, exp_a});
    check("R5 ttype", {59'd0, ttype_out}, {59'd0, tt});
    check("R8 dbus", {63'd0, dbus_req}, {63'd0, exp_d});
    start_in = 1'b1; addr_in = exp_a; ttype_in = tt;
    if (ackd == 0) aack_in = 1'b1;
    for (int i = 0; i < ackd; i++) begin
      @(negedge clk);
      start_in = 1'b0;
      if (i == 0) check("R9 own strobe not snooped", {63'd0, snoop_valid}, 64'd0);
      check("R4 strobe negated", {61'd0, start_out, busy_out, dbus_req}, 64'd2);
      check("R5 hold", {32'd0, addr_out}, {32'd0, exp_a});
      req_valid = 1'b1; req_addr = ~a; req_ttype = ~tt;
      check("R10 ready low in tenure", {63'd0, req_ready}, 64'd0);
      if (i == ackd - 1) begin
        req_valid = 1'b0;
        aack_in = 1'b1;
      end
    end
    @(negedge clk);
    aack_in = 1'b0; start_in = 1'b0;
    check("R7 release", {59'd0, start_oe, addr_oe, busy_out, busy_oe, req_ready}, 64'd2);
    if (ackd == 0) check("R9 own strobe not snooped", {63'd0, snoop_valid}, 64'd0);
    @(negedge clk);
    check("R7 busy released", {62'd0, busy_oe, req_ready}, 64'd1);
    @(negedge clk);
    check("R10 no extra request", {63'd0, bus_req}, 64'd0);
  endtask

  task automatic snoop(input logic [31:0] a, input logic [4:0] tt);
    @(negedge clk);
    busy_in = 1'b1; start_in = 1'b1; addr_in = a; ttype_in = tt;
    @(negedge clk);
    start_in = 1'b0; addr_in = 32'hdead_beef; ttype_in = 5'h1f;
    check("R9 snoop pulse", {63'd0, snoop_valid}, 64'd1);
    check("R9 snoop addr", {32'd0, snoop_addr}, {32'd0, a});
    check("R9 snoop ttype", {59'd0, snoop_ttype}, {59'd0, tt});
    @(negedge clk);
    busy_in = 1'b0;
    check("R9 pulse one cycle", {63'd0, snoop_valid}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset outs", {56'd0, bus_req, start_out, busy_out, dbus_req, snoop_valid,
          start_oe, busy_oe, addr_oe}, 64'd0);
    check("R1 reset ready", {63'd0, req_ready}, 64'd1);
    for (int t = 0; t < 32; t++) begin
      tenure(32'h1000_0007 + t * 32'h0101_0103, t[4:0], t % 3, t % 4);
    end
    for (int t = 0; t < 8; t++) begin
      snoop(32'h8000_0000 ^ (t * 32'h0011_2233), t[4:0] ^ 5'h15);
    end
    tenure(32'hffff_ffff, 5'h1f, 0, 0);
    tenure(32'h0000_0005, 5'h02, 2, 1);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end
endmodule